// File: doc/BRIEF.md
# Supply Fault Logger and Alert Controller

This block watches the fault indications of four board supplies (a 12 V rail, a 5 V rail, a 3.3 V rail and a negative rail, at indices 0 to 3). It keeps a live status view and sticky fault records, and decides when the power switches must be held off. Three fault categories are tracked per supply: input undervoltage, output power-bad and overcurrent. An overcurrent only counts once it has lasted through a qualifying filter. A 20 µs window is expressed in clock cycles through `FILT_CYC`, so shorter load surges pass unnoticed. Each category has its own recovery policy. With auto-retry the switches may come back as soon as the live condition is gone. Without it they stay off until the host clears the sticky bit. An active-low alert line draws the host's attention to the categories that an 8-bit mask selects.

A two-bit configuration strap adapts the block to boards without the negative rail. In that case undervoltage and power-bad on supply 3 are not monitored. A further strap setting also asks the analog side to use 3.3 V thresholds on the 5 V input. Each overcurrent filter is a small state machine: `BRK_IDLE`, `BRK_CNT`, `BRK_TRIP`. `BRK_IDLE` goes to `BRK_CNT` on raw overcurrent. `BRK_CNT` goes to `BRK_TRIP` after `FILT_CYC` consecutive high samples. Both `BRK_CNT` and `BRK_TRIP` return to `BRK_IDLE` on any low sample. The switch policy machine has two states. `POL_RUN` goes to `POL_HOLD` whenever a hold condition exists, and `POL_HOLD` returns to `POL_RUN` when none remains.

The host reaches the block through a flat 8-entry byte register port with combinational read and a synchronous write.

Top module: `sfl_fault_logger`

## Requirements
- R1: A raw overcurrent on a supply becomes a fault only after it has been high on `FILT_CYC` consecutive clock edges. A run of `FILT_CYC-1` high samples leaves no trace. The overcurrent faults read at address 3, bit i for supply i.
- R2: On the edge where a hold condition first appears while running, `trip_req` goes high for exactly one cycle.
- R3: Fault bits are sticky. Undervoltage of supply i reads at address 2 bit i, power-bad at address 2 bit 4+i, and overcurrent at address 3 bit i. A bit is set on the edge after its condition is seen and stays set after the condition goes away.
- R4: Writing a 1 to a fault bit at address 2 or 3 clears it, and writing a 0 leaves it unchanged. If the condition is still present, the bit remains set.
- R5: With the category's auto-retry bit set (address 4: bit 0 undervoltage, bit 1 power-bad, bit 2 overcurrent), only a live condition holds the switches off. `retry_ok` returns once the condition is gone, and the sticky bit stays.
- R6: With the auto-retry bit clear, `retry_ok` stays low until the sticky bit is cleared and the condition is gone.
- R7: `alert_n` is low exactly when some category whose mask bit is set (address 5: bit 0 undervoltage, bit 1 power-bad, bit 2 overcurrent) has any sticky bit set. Mask bits 7:3 have no effect, and the mask resets to 0.
- R8: With `cfg_strap` not 00, supply 3 undervoltage and power-bad are ignored in status, fault bits and hold. With `cfg_strap[1]` set, `thr_low` is 1.
- R9: Address 0 reads live monitored `{pbad[3:0], uv[3:0]}`. Address 1 reads `{2'b00, sw_short, aux_stat[4:0]}`.
- R10: After reset all registers are 0, `trip_req` is 0, `retry_ok` is 1 and `alert_n` is 1.
- R11: Address 4 keeps bits 2:0 and reads 0 in bits 7:3. Address 5 keeps all 8 bits. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_raw | input | 4 | Live input undervoltage per supply |
| pbad_raw | input | 4 | Live output power-bad per supply |
| oc_raw | input | 4 | Unfiltered overcurrent per supply |
| sw_short | input | 1 | Possible switch-short indication |
| aux_stat | input | 5 | Live soft-start, bus reset, local reset, board select and converter states |
| cfg_strap | input | 2 | Supply configuration strap |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| trip_req | output | 1 | One-cycle request to turn all switches off |
| retry_ok | output | 1 | Switches may be on |
| alert_n | output | 1 | Active-low alert |
| thr_low | output | 1 | Selects 3.3 V thresholds on the 5 V input |

## Verification
The hardest state to reach is an overcurrent that lasts exactly as long as the filter window, one cycle more or one cycle less. The breaker also has to qualify on the same edge where the raw signal drops. Directed runs of `FILT_CYC-1` and `FILT_CYC` high samples pin that boundary. Random stimulus then toggles each overcurrent input with low probability, so runs near the window length occur often. Random register writes land mid-fault and change retry policy while holds are active. A cycle model in the bench predicts every output.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    localparam logic [2:0] RA_STAT_LIVE = 3'd0;
    localparam logic [2:0] RA_STAT_SIG  = 3'd1;
    localparam logic [2:0] RA_FLT_VP    = 3'd2;
    localparam logic [2:0] RA_FLT_OC    = 3'd3;
    localparam logic [2:0] RA_CTRL      = 3'd4;
    localparam logic [2:0] RA_AMASK     = 3'd5;

    localparam int CAT_UV = 0;
    localparam int CAT_PB = 1;
    localparam int CAT_OC = 2;
    localparam int NCAT   = 3;

    typedef enum logic [1:0] {
        BRK_IDLE = 2'd0,
        BRK_CNT  = 2'd1,
        BRK_TRIP = 2'd2
    } brk_state_e;

    typedef enum logic {
        POL_RUN  = 1'b0,
        POL_HOLD = 1'b1
    } pol_state_e;

endpackage

// File: rtl/sfl_breaker.sv
module sfl_breaker
    import sfl_pkg::*;
#(
    parameter int FILT_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_raw,
    output logic oc_qual
);
    localparam int CW = $clog2(FILT_CYC + 1);

    brk_state_e      st, st_nx;
    logic [CW-1:0]   cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= BRK_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            BRK_IDLE: begin
                if (oc_raw) begin
                    cnt_nx = CW'(1);
                    st_nx  = (FILT_CYC <= 1) ? BRK_TRIP : BRK_CNT;
                end
            end
            BRK_CNT: begin
                if (!oc_raw) begin
                    st_nx  = BRK_IDLE;
                    cnt_nx = '0;
                end else if (cnt == CW'(FILT_CYC - 1)) begin
                    st_nx  = BRK_TRIP;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            BRK_TRIP: begin
                if (!oc_raw) begin
                    st_nx  = BRK_IDLE;
                    cnt_nx = '0;
                end
            end
            default: begin
                st_nx  = BRK_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    always_comb begin
        oc_qual = (st == BRK_TRIP);
    end

    // R1
    brk_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_qual) |-> $past(oc_raw));

    // R1
    brk_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BRK_CNT) |-> (cnt < CW'(FILT_CYC)));

endmodule

// File: rtl/sfl_policy.sv
module sfl_policy
    import sfl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_cond,
    output logic trip_req,
    output logic retry_ok
);
    pol_state_e st, st_nx;
    logic       trip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= POL_RUN;
            trip_q <= 1'b0;
        end else begin
            st     <= st_nx;
            trip_q <= (st == POL_RUN) && hold_cond;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            POL_RUN:  if (hold_cond)  st_nx = POL_HOLD;
            POL_HOLD: if (!hold_cond) st_nx = POL_RUN;
            default:  st_nx = POL_RUN;
        endcase
    end

    always_comb begin
        trip_req = trip_q;
        retry_ok = (st == POL_RUN);
    end

    // R2
    trip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_req |=> !trip_req);

    // R2
    trip_vs_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_req |-> !retry_ok);

    // R2
    run_to_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_ok && hold_cond) |=> trip_req);

endmodule

// File: rtl/sfl_regs.sv
module sfl_regs
    import sfl_pkg::*;
#(
    parameter int NSUP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic [NSUP-1:0] uv_live,
    input  logic [NSUP-1:0] pb_live,
    input  logic [NSUP-1:0] oc_live,
    input  logic [7:0]      sig_stat,
    output logic [NSUP-1:0] uv_lat,
    output logic [NSUP-1:0] pb_lat,
    output logic [NSUP-1:0] oc_lat,
    output logic [NCAT-1:0] retry_mode,
    output logic            alert_n
);
    logic [7:0]      amask;
    logic [7:0]      clr_vp;
    logic [7:0]      clr_oc;
    logic [NCAT-1:0] cat_hit;

    always_comb begin
        clr_vp = (reg_wr && reg_addr == RA_FLT_VP) ? reg_wdata : 8'h00;
        clr_oc = (reg_wr && reg_addr == RA_FLT_OC) ? reg_wdata : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_lat     <= '0;
            pb_lat     <= '0;
            oc_lat     <= '0;
            retry_mode <= '0;
            amask      <= '0;
        end else begin
            uv_lat <= (uv_lat & ~clr_vp[NSUP-1:0])      | uv_live;
            pb_lat <= (pb_lat & ~clr_vp[2*NSUP-1:NSUP]) | pb_live;
            oc_lat <= (oc_lat & ~clr_oc[NSUP-1:0])      | oc_live;
            if (reg_wr && reg_addr == RA_CTRL)  retry_mode <= reg_wdata[NCAT-1:0];
            if (reg_wr && reg_addr == RA_AMASK) amask      <= reg_wdata;
        end
    end

    always_comb begin
        cat_hit[CAT_UV] = |uv_lat;
        cat_hit[CAT_PB] = |pb_lat;
        cat_hit[CAT_OC] = |oc_lat;
        alert_n = ~|(amask[NCAT-1:0] & cat_hit);
    end

    always_comb begin
        case (reg_addr)
            RA_STAT_LIVE: reg_rdata = 8'({pb_live, uv_live});
            RA_STAT_SIG:  reg_rdata = sig_stat;
            RA_FLT_VP:    reg_rdata = 8'({pb_lat, uv_lat});
            RA_FLT_OC:    reg_rdata = 8'(oc_lat);
            RA_CTRL:      reg_rdata = 8'(retry_mode);
            RA_AMASK:     reg_rdata = amask;
            default:      reg_rdata = 8'h00;
        endcase
    end

    // R3
    uv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_live) |=> ((uv_lat & $past(uv_live)) == $past(uv_live)));

    // R3
    oc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_live) |=> ((oc_lat & $past(oc_live)) == $past(oc_live)));

    // R4
    oc_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_FLT_OC && (&reg_wdata[NSUP-1:0]) && oc_live == '0)
        |=> (oc_lat == '0));

    // R7
    alert_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amask[NCAT-1:0] == '0) |-> alert_n);

endmodule

// File: rtl/sfl_fault_logger.sv
module sfl_fault_logger
    import sfl_pkg::*;
#(
    parameter int NSUP     = 4,
    parameter int FILT_CYC = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUP-1:0] uv_raw,
    input  logic [NSUP-1:0] pbad_raw,
    input  logic [NSUP-1:0] oc_raw,
    input  logic            sw_short,
    input  logic [4:0]      aux_stat,
    input  logic [1:0]      cfg_strap,
    input  logic [2:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            trip_req,
    output logic            retry_ok,
    output logic            alert_n,
    output logic            thr_low
);
    localparam int NEG_IDX = NSUP - 1;

    logic [NSUP-1:0] mon_mask;
    logic [NSUP-1:0] uv_live, pb_live, oc_live;
    logic [NSUP-1:0] uv_lat, pb_lat, oc_lat;
    logic [NSUP-1:0] hold_uv, hold_pb, hold_oc;
    logic [NCAT-1:0] retry_mode;
    logic [7:0]      sig_stat;
    logic            hold_cond;

    for (genvar i = 0; i < NSUP; i++) begin : g_sup
        assign mon_mask[i] = (i == NEG_IDX) ? (cfg_strap == 2'b00) : 1'b1;

        sfl_breaker #(.FILT_CYC(FILT_CYC)) u_brk (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc_raw  (oc_raw[i]),
            .oc_qual (oc_live[i])
        );
    end

    always_comb begin
        uv_live  = uv_raw & mon_mask;
        pb_live  = pbad_raw & mon_mask;
        sig_stat = {2'b00, sw_short, aux_stat};
        thr_low  = cfg_strap[1];
        hold_uv  = retry_mode[CAT_UV] ? uv_live : (uv_live | uv_lat);
        hold_pb  = retry_mode[CAT_PB] ? pb_live : (pb_live | pb_lat);
        hold_oc  = retry_mode[CAT_OC] ? oc_live : (oc_live | oc_lat);
        hold_cond = (|hold_uv) | (|hold_pb) | (|hold_oc);
    end

    sfl_regs #(.NSUP(NSUP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .uv_live    (uv_live),
        .pb_live    (pb_live),
        .oc_live    (oc_live),
        .sig_stat   (sig_stat),
        .uv_lat     (uv_lat),
        .pb_lat     (pb_lat),
        .oc_lat     (oc_lat),
        .retry_mode (retry_mode),
        .alert_n    (alert_n)
    );

    sfl_policy u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_cond (hold_cond),
        .trip_req  (trip_req),
        .retry_ok  (retry_ok)
    );

    // R8
    neg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_strap != 2'b00) |-> (uv_live[NEG_IDX] == 1'b0 && pb_live[NEG_IDX] == 1'b0));

    // R6
    latched_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|oc_lat) && !retry_mode[CAT_OC]) |=> !retry_ok);

endmodule

// File: tb/tb_sfl_fault_logger.sv
`timescale 1ns/1ps
module tb_sfl_fault_logger;
    localparam int FILT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0] uv, pb, oc;
    logic       sw;
    logic [4:0] aux;
    logic [1:0] strap;
    logic [2:0] addr;
    logic       wr;
    logic [7:0] wdata;
    wire  [7:0] rdata;
    wire        trip_req, retry_ok, alert_n, thr_low;

    sfl_fault_logger #(.NSUP(4), .FILT_CYC(FILT)) dut (
        .clk(clk), .rst_n(rst_n), .uv_raw(uv), .pbad_raw(pb), .oc_raw(oc),
        .sw_short(sw), .aux_stat(aux), .cfg_strap(strap), .reg_addr(addr),
        .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .trip_req(trip_req),
        .retry_ok(retry_ok), .alert_n(alert_n), .thr_low(thr_low)
    );

    int n_chk = 0;
    int n_bad = 0;

    int         m_bst [4];
    int         m_cnt [4];
    logic [3:0] m_uvl, m_pbl, m_ocl;
    logic [2:0] m_ctrl;
    logic [7:0] m_mask;
    logic       m_run, m_trip;

    function automatic logic [3:0] f_mon(logic [1:0] s);
        return (s == 2'b00) ? 4'hF : 4'h7;
    endfunction

    function automatic logic [7:0] f_read(logic [2:0] a);
        logic [3:0] mk;
        mk = f_mon(strap);
        case (a)
            3'd0: return {pb & mk, uv & mk};
            3'd1: return {2'b00, sw, aux};
            3'd2: return {m_pbl, m_uvl};
            3'd3: return {4'h0, m_ocl};
            3'd4: return {5'b0, m_ctrl};
            3'd5: return m_mask;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic f_alert();
        logic hit;
        hit = (m_mask[0] & |m_uvl) | (m_mask[1] & |m_pbl) | (m_mask[2] & |m_ocl);
        return ~hit;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string rt;
        case (addr)
            3'd0, 3'd1: rt = "R9 status read";
            3'd2, 3'd3: rt = "R3 fault read";
            default:    rt = "R11 register read";
        endcase
        chk("R2 trip_req", {7'b0, trip_req}, {7'b0, m_trip});
        chk("R6 retry_ok", {7'b0, retry_ok}, {7'b0, m_run});
        chk("R7 alert_n", {7'b0, alert_n}, {7'b0, f_alert()});
        chk("R8 thr_low", {7'b0, thr_low}, {7'b0, strap[1]});
        chk(rt, rdata, f_read(addr));
    endtask

    task automatic model_edge();
        logic [3:0] mk, uvl, pbl, ocq, cvp, coc, hu, hp, ho;
        logic       blk;
        mk = f_mon(strap);
        uvl = uv & mk;
        pbl = pb & mk;
        for (int i = 0; i < 4; i++) ocq[i] = (m_bst[i] == 2);
        hu = m_ctrl[0] ? uvl : (uvl | m_uvl);
        hp = m_ctrl[1] ? pbl : (pbl | m_pbl);
        ho = m_ctrl[2] ? ocq : (ocq | m_ocl);
        blk = (|hu) | (|hp) | (|ho);
        cvp = 4'h0; coc = 4'h0;
        m_trip = m_run & blk;
        m_run = !blk;
        if (wr && addr == 3'd2) begin
            m_uvl = (m_uvl & ~wdata[3:0]) | uvl;
            m_pbl = (m_pbl & ~wdata[7:4]) | pbl;
        end else begin
            m_uvl = m_uvl | uvl;
            m_pbl = m_pbl | pbl;
        end
        if (wr && addr == 3'd3) coc = wdata[3:0];
        m_ocl = (m_ocl & ~coc) | ocq | cvp;
        if (wr && addr == 3'd4) m_ctrl = wdata[2:0];
        if (wr && addr == 3'd5) m_mask = wdata;
        for (int i = 0; i < 4; i++) begin
            case (m_bst[i])
                0: if (oc[i]) begin m_cnt[i] = 1; m_bst[i] = (FILT <= 1) ? 2 : 1; end
                1: begin
                    if (!oc[i]) begin m_bst[i] = 0; m_cnt[i] = 0; end
                    else if (m_cnt[i] == FILT - 1) m_bst[i] = 2;
                    else m_cnt[i]++;
                end
                default: if (!oc[i]) begin m_bst[i] = 0; m_cnt[i] = 0; end
            endcase
        end
    endtask

    task automatic step();
        #1;
        check_all();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic rexp(logic [2:0] a, logic [7:0] e, string tag);
        addr = a;
        #1;
        chk(tag, rdata, e);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        uv = 0; pb = 0; oc = 0; sw = 0; aux = 0; strap = 0;
        addr = 0; wr = 0; wdata = 0;
        for (int i = 0; i < 4; i++) begin m_bst[i] = 0; m_cnt[i] = 0; end
        m_uvl = 0; m_pbl = 0; m_ocl = 0; m_ctrl = 0; m_mask = 0;
        m_run = 1; m_trip = 0;
        void'($urandom(32'd24681));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        #1;
        chk("R10 trip_req", {7'b0, trip_req}, 8'h00);
        chk("R10 retry_ok", {7'b0, retry_ok}, 8'h01);
        chk("R10 alert_n", {7'b0, alert_n}, 8'h01);
        rexp(3'd2, 8'h00, "R10 faults");
        rexp(3'd4, 8'h00, "R10 ctrl");
        rexp(3'd5, 8'h00, "R10 mask");
        addr = 0;
        step();

        // R1 short surge ignored
        oc = 4'b0001;
        steps(FILT - 1);
        oc = 4'b0000;
        steps(3);
        rexp(3'd3, 8'h00, "R1 short surge");
        chk("R1 retry kept", {7'b0, retry_ok}, 8'h01);

        // R1 qualifying surge
        oc = 4'b0001;
        steps(FILT);
        oc = 4'b0000;
        steps(2);
        rexp(3'd3, 8'h01, "R1 qualified trip");
        chk("R6 latched off", {7'b0, retry_ok}, 8'h00);

        // R4 write zero, then write one
        wreg(3'd3, 8'h00);
        rexp(3'd3, 8'h01, "R4 zero write");
        wreg(3'd3, 8'h01);
        rexp(3'd3, 8'h00, "R4 one clears");
        steps(2);
        chk("R6 released", {7'b0, retry_ok}, 8'h01);

        // R4 clear while condition live
        uv = 4'b0010;
        steps(2);
        wreg(3'd2, 8'h02);
        rexp(3'd2, 8'h02, "R4 live re-set");
        uv = 4'b0000;
        steps(2);
        chk("R6 still held", {7'b0, retry_ok}, 8'h00);

        // R5 auto-retry
        wreg(3'd4, 8'h01);
        steps(2);
        chk("R5 retry resumes", {7'b0, retry_ok}, 8'h01);
        rexp(3'd2, 8'h02, "R5 sticky kept");
        uv = 4'b0010;
        steps(2);
        chk("R5 live holds", {7'b0, retry_ok}, 8'h00);
        uv = 4'b0000;
        steps(2);
        chk("R5 released", {7'b0, retry_ok}, 8'h01);

        // R7 alert masking
        wreg(3'd5, 8'h02);
        chk("R7 unmasked quiet", {7'b0, alert_n}, 8'h01);
        wreg(3'd5, 8'h01);
        chk("R7 masked alert", {7'b0, alert_n}, 8'h00);
        wreg(3'd5, 8'hF8);
        chk("R7 high bits inert", {7'b0, alert_n}, 8'h01);
        wreg(3'd5, 8'h07);
        wreg(3'd2, 8'hFF);
        chk("R7 release", {7'b0, alert_n}, 8'h01);

        // R8 strap
        strap = 2'b01; uv = 4'b1000; pb = 4'b1000;
        rexp(3'd0, 8'h00, "R8 neg ignored status");
        chk("R8 thr normal", {7'b0, thr_low}, 8'h00);
        steps(2);
        rexp(3'd2, 8'h00, "R8 neg not latched");
        strap = 2'b10;
        #1;
        chk("R8 thr low", {7'b0, thr_low}, 8'h01);
        strap = 2'b00;
        rexp(3'd0, 8'h88, "R9 live status");
        steps(2);
        uv = 0; pb = 0;
        steps(1);
        wreg(3'd2, 8'hFF);

        // R11 register fields
        wreg(3'd4, 8'hFF);
        rexp(3'd4, 8'h07, "R11 ctrl width");
        wreg(3'd5, 8'hA5);
        rexp(3'd5, 8'hA5, "R11 mask");
        rexp(3'd6, 8'h00, "R11 unused");
        sw = 1'b1; aux = 5'b10110;
        rexp(3'd1, 8'h36, "R9 signal status");
        wreg(3'd4, 8'h00);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int k;
            if ($urandom_range(7) == 0) begin k = $urandom_range(3); uv[k] = ~uv[k]; end
            if ($urandom_range(7) == 0) begin k = $urandom_range(3); pb[k] = ~pb[k]; end
            if ($urandom_range(5) == 0) begin k = $urandom_range(3); oc[k] = ~oc[k]; end
            if ($urandom_range(63) == 0) strap = 2'($urandom_range(3));
            sw = 1'($urandom);
            aux = 5'($urandom);
            addr = 3'($urandom_range(7));
            wr = ($urandom_range(9) == 0);
            wdata = 8'($urandom);
            step();
        end
        wr = 1'b0;
        step();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule